// File: doc/BRIEF.md
# Multi-Format I/Q Double-Data-Rate Lane Serializer

This block takes complex baseband samples one at a time, each with an I word, a Q word and a 4-bit gain word. It spreads each sample over a narrow group of output lanes at double data rate. Every core clock carries two beats: a rising beat and a falling beat. A 3-bit format code picks one of six lane layouts. There are three lane widths (9, 4 or 2 lanes), and each width has a plain I/Q variant and a variant that carries gain bits inside the sample. Samples are numbered as channels of a frame whose length is set at run time. The first channel of every frame is marked by a sync output. A forwarded-clock pattern is high on rising beats and low on falling beats while a sample is on the lanes.

The controller is a two-state machine. `ST_IDLE` means nothing is on the lanes. `ST_SEND` means a sample is being shifted out, one clock index per core clock. The transitions are:
- IDLE→SEND when a sample is accepted.
- SEND→SEND, staying in the state, while clocks remain in the sample.
- SEND→SEND with a reload when a new sample is accepted on the final clock.
- SEND→IDLE when the final clock passes and no sample is offered.

Format and frame length are sampled only when a channel-0 sample is accepted. They then hold for the whole frame.

Top module: `bbs_lane_ser`

## Requirements
- R1: After reset the block is in ST_IDLE. `in_ready` is 1, and all lanes, `frame_sync`, `fclk_rise` and `fclk_fall` are 0.
- R2: Format code 0 uses four beats over lanes 0..8 in this order: I odd bits, I even bits, Q odd bits, Q even bits. On an odd-bit beat lane k carries bit 2k+1, and on an even-bit beat it carries bit 2k, with bit 0 as the LSB.
- R3: Format code 1 sends the same four beats over 16-bit I and Q on lanes 0..7. Lane 8 carries gain bits 3, 2, 1 and 0 on beats 0..3.
- R4: Format code 2 uses eight beats on lanes 0..3. The word {I[15:0],Q[15:0]} is sent as 4-bit groups, most significant group first, with lanes 4..8 held at 0.
- R5: Format code 3 uses eight 4-bit beats of the word {I[13:0],Q[13:0],gain[3:0]}, most significant group first, on lanes 0..3.
- R6: Format code 4 uses sixteen beats on lanes 0..1. The word {I[15:0],Q[15:0]} is sent as 2-bit pairs, most significant pair first.
- R7: Format code 5 uses sixteen 2-bit beats of {I[13:0],Q[13:0],gain[3:0]}, most significant pair first.
- R8: Beat 2c appears on `lane_rise` and beat 2c+1 on `lane_fall` in the c-th clock after acceptance. A sample takes 2, 4 or 8 clocks for the 9-, 4- or 2-lane formats. While sending, `fclk_rise` is 1 and `fclk_fall` is 0.
- R9: `in_ready` is 1 only in ST_IDLE or on the final clock of a sample. A sample accepted on the final clock starts on the very next clock, with no gap.
- R10: In ST_IDLE all lanes and `frame_sync` are 0.
- R11: `frame_sync` is 1 on every clock of a channel-0 sample and 0 on the other channels. The channel index wraps to 0 after frame length − 1.
- R12: Format and length inputs are sampled only when a channel-0 sample is accepted. Changes during a frame take effect at the next frame.
- R13: Length 0 is treated as 1, lengths above 48 are treated as 48, and format codes 6 and 7 are treated as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be taken this clock |
| in_i | input | 18 | In-phase word |
| in_q | input | 18 | Quadrature word |
| in_gain | input | 4 | Gain word |
| fmt_sel | input | 3 | Lane format code |
| frame_len | input | 6 | Channels per frame |
| lane_rise | output | 9 | Lane values on the rising beat |
| lane_fall | output | 9 | Lane values on the falling beat |
| frame_sync | output | 1 | High during channel 0 |
| fclk_rise | output | 1 | Forwarded clock, rising beat |
| fclk_fall | output | 1 | Forwarded clock, falling beat |

## Verification
Each of the six formats is driven with I, Q and gain words whose bit patterns differ from sample to sample. A swapped odd/even split, a reversed group order or a misplaced gain bit therefore shows as a lane mismatch. Back-to-back samples separate a gapless reload from an off-by-one in the clock index, and idle gaps confirm that the lanes fall quiet. Format and length changes made mid-frame show whether the latch waits for channel 0. Frames of length 0, 60 and 3, together with format code 7, exercise the clamping and the wrap of the channel counter.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
    localparam int LANES     = 9;
    localparam int SMP_W     = 18;
    localparam int GAIN_W    = 4;
    localparam int MAX_CH    = 48;
    localparam int MAX_BEATS = 16;
    localparam int WORD_W    = 32;
    localparam int CH_W      = $clog2(MAX_CH);
    localparam int LEN_W     = $clog2(MAX_CH + 1);
    localparam int CLK_W     = $clog2(MAX_BEATS / 2);
    localparam int BEAT_W    = $clog2(MAX_BEATS);

    typedef enum logic [2:0] {
        FMT_BYTE   = 3'd0,
        FMT_BYTE_G = 3'd1,
        FMT_NIB    = 3'd2,
        FMT_NIB_G  = 3'd3,
        FMT_SER    = 3'd4,
        FMT_SER_G  = 3'd5
    } fmt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } st_e;

    function automatic fmt_e fmt_clean(input logic [2:0] code);
        return (code > 3'd5) ? FMT_BYTE : fmt_e'(code);
    endfunction

    function automatic logic [LEN_W-1:0] len_clean(input logic [LEN_W-1:0] l);
        if (l == '0)
            return LEN_W'(1);
        else if (l > LEN_W'(MAX_CH))
            return LEN_W'(MAX_CH);
        else
            return l;
    endfunction

    function automatic logic [CLK_W-1:0] last_clk(input fmt_e f);
        case (f)
            FMT_BYTE, FMT_BYTE_G: return CLK_W'(1);
            FMT_NIB, FMT_NIB_G:   return CLK_W'(3);
            default:              return CLK_W'(7);
        endcase
    endfunction
endpackage

// File: rtl/bbs_beat_pack.sv
module bbs_beat_pack
    import bbs_pkg::*;
(
    input  fmt_e                              fmt,
    input  logic [SMP_W-1:0]                  s_i,
    input  logic [SMP_W-1:0]                  s_q,
    input  logic [GAIN_W-1:0]                 s_g,
    output logic [MAX_BEATS-1:0][LANES-1:0]   beats
);
    logic [WORD_W-1:0] pk_word;
    logic              gain_fmt;

    always_comb begin
        gain_fmt = (fmt == FMT_NIB_G) || (fmt == FMT_SER_G);
        if (gain_fmt)
            pk_word = {s_i[13:0], s_q[13:0], s_g};
        else
            pk_word = {s_i[15:0], s_q[15:0]};
    end

    for (genvar b = 0; b < MAX_BEATS; b++) begin : g_beat
        logic [LANES-1:0] v_byte;
        logic [LANES-1:0] v_nib;
        logic [LANES-1:0] v_ser;
        logic             v_gbit;
        logic [LANES-1:0] sel;

        if (b < 4) begin : g_byte
            localparam int ODD = (b % 2 == 0) ? 1 : 0;
            logic [SMP_W-1:0] comp;
            assign comp   = (b < 2) ? s_i : s_q;
            assign v_gbit = s_g[GAIN_W-1-b];
            always_comb begin
                for (int k = 0; k < LANES; k++)
                    v_byte[k] = comp[2*k + ODD];
            end
        end else begin : g_nobyte
            assign v_byte = '0;
            assign v_gbit = 1'b0;
        end

        if (b < 8) begin : g_nib
            assign v_nib = {{(LANES-4){1'b0}}, pk_word[WORD_W-1-4*b -: 4]};
        end else begin : g_nonib
            assign v_nib = '0;
        end

        assign v_ser = {{(LANES-2){1'b0}}, pk_word[WORD_W-1-2*b -: 2]};

        always_comb begin
            unique case (fmt)
                FMT_BYTE:           sel = v_byte;
                FMT_BYTE_G:         sel = {v_gbit, v_byte[LANES-2:0]};
                FMT_NIB, FMT_NIB_G: sel = v_nib;
                FMT_SER, FMT_SER_G: sel = v_ser;
                default:            sel = '0;
            endcase
        end

        assign beats[b] = sel;
    end
endmodule

// File: rtl/bbs_frame_ctl.sv
module bbs_frame_ctl
    import bbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       fmt_code,
    input  logic [LEN_W-1:0] len_code,
    output logic             in_ready,
    output logic             accept,
    output st_e              state,
    output logic [CLK_W-1:0] clk_idx,
    output logic [CH_W-1:0]  cur_ch,
    output fmt_e             fmt_q
);
    st_e              state_n;
    logic [CH_W-1:0]  next_ch;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_use;
    logic             on_last;
    logic             frame_start;

    // Output / handshake process
    always_comb begin
        on_last     = (state == ST_SEND) && (clk_idx == last_clk(fmt_q));
        in_ready    = (state == ST_IDLE) || on_last;
        accept      = in_valid && in_ready;
        frame_start = (next_ch == '0);
        len_use     = frame_start ? len_clean(len_code) : len_q;
    end

    // Next-state process
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: state_n = accept ? ST_SEND : ST_IDLE;
            ST_SEND: begin
                if (on_last)
                    state_n = accept ? ST_SEND : ST_IDLE;
                else
                    state_n = ST_SEND;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            clk_idx <= '0;
            next_ch <= '0;
            cur_ch  <= '0;
            fmt_q   <= FMT_BYTE;
            len_q   <= LEN_W'(1);
        end else begin
            state <= state_n;
            if (accept) begin
                clk_idx <= '0;
                cur_ch  <= next_ch;
                if (next_ch == CH_W'(len_use - 1'b1))
                    next_ch <= '0;
                else
                    next_ch <= next_ch + 1'b1;
                if (frame_start) begin
                    fmt_q <= fmt_clean(fmt_code);
                    len_q <= len_use;
                end
            end else if ((state == ST_SEND) && !on_last) begin
                clk_idx <= clk_idx + 1'b1;
            end
        end
    end

    a_r9_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state == ST_SEND) && (clk_idx == '0));

    a_r8_clock_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SEND) && !on_last && !accept) |=> (clk_idx == CLK_W'($past(clk_idx) + 1'b1)));

    a_r12_fmt_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && frame_start) |=> $stable(fmt_q));

    a_r13_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q >= LEN_W'(1)) && (len_q <= LEN_W'(MAX_CH)));

    a_r11_ch_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND) |-> (cur_ch < CH_W'(len_q)));
endmodule

// File: rtl/bbs_lane_ser.sv
module bbs_lane_ser
    import bbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [17:0]      in_i,
    input  logic [17:0]      in_q,
    input  logic [3:0]       in_gain,
    input  logic [2:0]       fmt_sel,
    input  logic [5:0]       frame_len,
    output logic [8:0]       lane_rise,
    output logic [8:0]       lane_fall,
    output logic             frame_sync,
    output logic             fclk_rise,
    output logic             fclk_fall
);
    logic                             accept;
    st_e                              state;
    logic [CLK_W-1:0]                 clk_idx;
    logic [CH_W-1:0]                  cur_ch;
    fmt_e                             fmt_q;
    logic [SMP_W-1:0]                 s_i;
    logic [SMP_W-1:0]                 s_q;
    logic [GAIN_W-1:0]                s_g;
    logic [MAX_BEATS-1:0][LANES-1:0]  beats;
    logic [BEAT_W-1:0]                idx_r;
    logic [BEAT_W-1:0]                idx_f;
    logic                             sending;

    bbs_frame_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .fmt_code (fmt_sel),
        .len_code (frame_len),
        .in_ready (in_ready),
        .accept   (accept),
        .state    (state),
        .clk_idx  (clk_idx),
        .cur_ch   (cur_ch),
        .fmt_q    (fmt_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_i <= '0;
            s_q <= '0;
            s_g <= '0;
        end else if (accept) begin
            s_i <= in_i;
            s_q <= in_q;
            s_g <= in_gain;
        end
    end

    bbs_beat_pack u_pack (
        .fmt   (fmt_q),
        .s_i   (s_i),
        .s_q   (s_q),
        .s_g   (s_g),
        .beats (beats)
    );

    always_comb begin
        sending    = (state == ST_SEND);
        idx_r      = {clk_idx, 1'b0};
        idx_f      = {clk_idx, 1'b1};
        lane_rise  = sending ? beats[idx_r] : '0;
        lane_fall  = sending ? beats[idx_f] : '0;
        frame_sync = sending && (cur_ch == '0);
        fclk_rise  = sending;
        fclk_fall  = 1'b0;
    end

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fclk_rise |-> (lane_rise == '0) && (lane_fall == '0) && !frame_sync);

    a_r4_narrow_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (fclk_rise && (fmt_q != FMT_BYTE) && (fmt_q != FMT_BYTE_G))
            |-> (lane_rise[8:4] == '0) && (lane_fall[8:4] == '0));

    a_r9_no_take_midsample: assert property (@(posedge clk) disable iff (!rst_n)
        (fclk_rise && !in_ready) |=> fclk_rise);
endmodule

// File: tb/bbs_lane_ser_tb_top.sv
module bbs_lane_ser_tb_top;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [17:0] in_i = '0;
    logic [17:0] in_q = '0;
    logic [3:0]  in_gain = '0;
    logic [2:0]  fmt_sel = '0;
    logic [5:0]  frame_len = 6'd1;
    logic [8:0]  lane_rise;
    logic [8:0]  lane_fall;
    logic        frame_sync;
    logic        fclk_rise;
    logic        fclk_fall;

    always #(CLK_NS/2) clk = ~clk;

    bbs_lane_ser dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_i(in_i), .in_q(in_q), .in_gain(in_gain), .fmt_sel(fmt_sel),
        .frame_len(frame_len), .lane_rise(lane_rise), .lane_fall(lane_fall),
        .frame_sync(frame_sync), .fclk_rise(fclk_rise), .fclk_fall(fclk_fall)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    bit running = 0;

    // Entry layout: {clamped, fmt[2:0], sync, rise[8:0], fall[8:0]}
    logic [22:0] q_exp[$];
    int m_next = 0;
    int m_fmt = 0;
    int m_len = 1;
    bit m_clamp = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [8:0] exp_beat(input int f, input logic [17:0] i,
                                            input logic [17:0] q, input logic [3:0] g, input int b);
        logic [8:0]  r;
        logic [17:0] src;
        logic [31:0] w;
        int          per;
        r = '0;
        if (f < 2) begin
            if (b < 4) begin
                src = (b < 2) ? i : q;
                for (int k = 0; k < 9; k++) r[k] = src[2*k + ((b % 2 == 0) ? 1 : 0)];
                if (f == 1) r[8] = g[3-b];
            end
        end else begin
            per = (f < 4) ? 4 : 2;
            if (f == 3 || f == 5) w = {i[13:0], q[13:0], g};
            else                  w = {i[15:0], q[15:0]};
            if (b * per < 32)
                for (int k = 0; k < per; k++) r[per-1-k] = w[31 - per*b - k];
        end
        return r;
    endfunction

    task automatic model_push(input logic [2:0] f, input logic [5:0] l,
                              input logic [17:0] i, input logic [17:0] q, input logic [3:0] g);
        int ch;
        int cpc;
        if (m_next == 0) begin
            m_clamp = (f > 5) || (l == 0) || (l > 48);
            m_fmt   = (f > 5) ? 0 : int'(f);
            m_len   = (l == 0) ? 1 : ((l > 48) ? 48 : int'(l));
        end
        ch = m_next;
        m_next = (m_next == m_len - 1) ? 0 : m_next + 1;
        cpc = (m_fmt < 2) ? 2 : ((m_fmt < 4) ? 4 : 8);
        for (int c = 0; c < cpc; c++)
            q_exp.push_back({m_clamp, 3'(m_fmt), (ch == 0),
                             exp_beat(m_fmt, i, q, g, 2*c), exp_beat(m_fmt, i, q, g, 2*c+1)});
    endtask

    task automatic send(input logic [2:0] f, input logic [5:0] l,
                        input logic [17:0] i, input logic [17:0] q, input logic [3:0] g);
        bit seen;
        @(negedge clk);
        in_valid = 1'b1; fmt_sel = f; frame_len = l;
        in_i = i; in_q = q; in_gain = g;
        forever begin
            seen = in_ready;
            @(posedge clk);
            if (seen) break;
            @(negedge clk);
        end
        #1 in_valid = 1'b0;
        model_push(f, l, i, q, g);
    endtask

    function automatic logic [17:0] mk(input int k);
        return 18'h2B4D6 ^ 18'(k * 32'h0001_3A7B) ^ 18'(k << 7);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        logic [22:0] e;
        string tag;
        if (rst_n && running) begin
            if (fclk_rise) begin
                if (q_exp.size() == 0) begin
                    chk(0, "R9 unexpected beat", {14'd0, lane_rise, lane_fall}, 32'd0);
                end else begin
                    e = q_exp.pop_front();
                    case (e[21:19])
                        3'd0: tag = "R2 byte";
                        3'd1: tag = "R3 byte gain";
                        3'd2: tag = "R4 nibble";
                        3'd3: tag = "R5 nibble gain";
                        3'd4: tag = "R6 serial";
                        default: tag = "R7 serial gain";
                    endcase
                    if (e[22]) tag = {"R13 clamped ", tag};
                    chk({lane_rise, lane_fall} == e[17:0], tag,
                        {14'd0, lane_rise, lane_fall}, {14'd0, e[17:0]});
                    chk(frame_sync == e[18], "R11 sync", {31'd0, frame_sync}, {31'd0, e[18]});
                    chk(fclk_fall == 1'b0, "R8 clock pattern", {31'd0, fclk_fall}, 32'd0);
                end
            end else begin
                chk((lane_rise == 0) && (lane_fall == 0) && !frame_sync && !fclk_fall,
                    "R10 idle quiet", {13'd0, frame_sync, lane_rise, lane_fall}, 32'd0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", q_exp.size(), 0);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1, "R1 ready", {31'd0, in_ready}, 32'd1);
        chk((lane_rise == 0) && (lane_fall == 0) && !frame_sync && !fclk_rise && !fclk_fall,
            "R1 outputs", {12'd0, fclk_rise, frame_sync, lane_rise, lane_fall}, 32'd0);
        @(negedge clk); rst_n = 1'b1; running = 1;
        chk(in_ready == 1'b1 && !fclk_rise, "R1 after release", {30'd0, in_ready, fclk_rise}, 32'd2);

        // byte plain, frame of 2, gapless
        for (int k = 0; k < 4; k++) send(3'd0, 6'd2, mk(k), mk(k+50), 4'(k));
        // byte gain
        for (int k = 0; k < 2; k++) send(3'd1, 6'd2, mk(k+7), mk(k+90), 4'(4'hA ^ k));
        idle(3);
        // nibble plain; R9 ready low mid-sample
        send(3'd2, 6'd1, mk(11), mk(12), 4'h0);
        @(negedge clk);
        chk(in_ready == 1'b0, "R9 ready low mid-sample", {31'd0, in_ready}, 32'd0);
        for (int k = 0; k < 2; k++) send(3'd2, 6'd1, mk(k+13), mk(k+33), 4'h0);
        // nibble gain
        for (int k = 0; k < 2; k++) send(3'd3, 6'd1, mk(k+21), mk(k+41), 4'(4'h5 + k));
        // serial plain, frame of 3
        for (int k = 0; k < 3; k++) send(3'd4, 6'd3, mk(k+61), mk(k+71), 4'h0);
        // serial gain with idle gap between
        send(3'd5, 6'd1, mk(81), mk(82), 4'hC);
        idle(4);
        send(3'd5, 6'd1, mk(83), mk(84), 4'h3);
        // R12: format/length changes mid-frame ignored until channel 0
        send(3'd0, 6'd3, mk(91), mk(92), 4'h0);
        send(3'd2, 6'd1, mk(93), mk(94), 4'h0);
        send(3'd2, 6'd1, mk(95), mk(96), 4'h0);
        send(3'd2, 6'd1, mk(97), mk(98), 4'h0);
        // R13: code 7 and length 0
        for (int k = 0; k < 2; k++) send(3'd7, 6'd0, mk(k+101), mk(k+111), 4'h0);
        // R13: length 60 clamps to 48, wrap checked by sync
        for (int k = 0; k < 49; k++) send(3'd0, 6'd60, mk(k+200), mk(k+300), 4'h0);
        idle(12);
        chk(q_exp.size() == 0, "R8 all beats delivered", q_exp.size(), 32'd0);
        finish_run();
    end
endmodule